// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block remaps bus addresses that fall inside a fixed aperture window onto physical memory, one 4 KiB page at a time. It holds a single-level table with one entry per aperture page. Each entry has a valid flag and a physical page frame. A translation request that hits an enabled, valid entry returns the physical address. Any other request returns a fault: translation switched off, an address outside the window, or an entry that is not mapped.

Software never sees the table as memory. It programs the table through a small register file. First it writes the bus address of a page into an entry-address register. Then it writes or reads an entry-data port, and the access reaches the entry that the latched address selects. A one-bit global enable gates every translation. Software can read the configuration register back at any time, with no side effect, to confirm that its earlier register writes have completed.

Top module: `aperture_remap`

## Requirements
- R1: After reset the enable bit is 0, the entry-address register reads 0 and every table entry is 0, so an enabled translation of any aperture page faults until that page is mapped.
- R2: A write to offset 0x0 loads bit 0 into the enable bit. A read of offset 0x0 returns 31 zero bits followed by the enable bit and changes no state.
- R3: A write to offset 0x4 latches a page address. A following write to offset 0x8 stores bits 31..12 of the write data into the selected entry. Bits 11..0 are not stored and read back as zero.
- R4: A read presented with regRdEn appears on regRdData after the next rising clock edge, and regRdData holds that value until the next read. A read of offset 0x8 returns the selected entry.
- R5: A translation request appears on the response one cycle later with respValid high. It hits when translation is enabled, the address is in the aperture and entry bit 31 (the valid flag) is set. A hit returns bit 31 = 0, bits 30..12 from entry bits 30..12, and bits 11..0 from the request, with respFault low.
- R6: While the enable bit is 0, every translation request faults and respAddr is 0.
- R7: A translation that reaches an entry with bit 31 clear faults and returns respAddr 0. This includes a page unmapped by writing an all-zero entry.
- R8: A request below APER_BASE, or at or above APER_BASE + NUM_ENTRIES*4096, faults.
- R9: If the latched entry address has any of bits 11..0 set, or lies outside the aperture, writes to offset 0x8 leave the table unchanged and reads of 0x8 and 0x4 return 0. Otherwise a read of 0x4 returns the latched page address.
- R10: When an entry-data write and a translation of the same page occur in the same cycle, the translation uses the entry value from before the write.
- R11: Reads of any other register offset return 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid the cycle after regRdEn |
| xlValid | input | 1 | Translation request valid |
| xlReady | output | 1 | Translation request accepted (always high) |
| xlAddr | input | 32 | Bus address to translate |
| respValid | output | 1 | Translation response valid |
| respFault | output | 1 | Translation faulted |
| respAddr | output | 32 | Translated physical address, 0 on fault |

## Verification
Properties in the RTL check four things on every cycle. An enable write takes effect one cycle later. Reads of the entry port through a rejected latched address return zero. Requests made while disabled or outside the window always fault. A response never carries both a fault and a nonzero address, and never sets bit 31. Other behaviours need the bench's scenarios: whether the correct frame is joined with the correct offset, whether writes through a rejected address truly leave the table untouched, how unmapping and remapping behave, the old-value ordering when a write and a translation meet in the same cycle, and whether reset truly clears the table.

// File: rtl/ar_pkg.sv
package ar_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int ENT_W      = 32 - PAGE_SHIFT;

  localparam logic [3:0] CFG_OFS   = 4'h0;
  localparam logic [3:0] EADDR_OFS = 4'h4;
  localparam logic [3:0] EDATA_OFS = 4'h8;

  // Strobes from control to datapath
  typedef struct packed {
    logic entryWr;
    logic xlEnable;
  } ar_strobe_t;

  // Half-open window test: base <= a < base + size
  function automatic logic inWindow(input logic [31:0] a, input logic [31:0] base,
                                    input logic [32:0] size);
    logic [31:0] off;
    off = a - base;
    return (a >= base) && ({1'b0, off} < size);
  endfunction
endpackage

// File: rtl/ar_ctrl.sv
module ar_ctrl
  import ar_pkg::*;
#(
  parameter logic [31:0] APER_BASE   = 32'h4000_0000,
  parameter int          NUM_ENTRIES = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [3:0]             regAddr,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic [31:0]            entryOut,
  output ar_strobe_t             strb,
  output logic [$clog2(NUM_ENTRIES)-1:0] entryIdx,
  output logic [ENT_W-1:0]       entryWdata
);
  localparam int          IDX_W     = $clog2(NUM_ENTRIES);
  localparam logic [32:0] APER_SIZE = 33'(NUM_ENTRIES) << PAGE_SHIFT;

  logic             enableQ;
  logic [IDX_W-1:0] idxQ;
  logic             idxOkQ;
  logic [31:0]      eaOff;
  logic             eaAccept;
  logic [31:0]      eaWord;
  logic [31:0]      rdNext;
  logic             wrCfg, wrEa;

  assign wrCfg    = regWrEn && (regAddr == CFG_OFS);
  assign wrEa     = regWrEn && (regAddr == EADDR_OFS);
  assign eaOff    = regWrData - APER_BASE;
  assign eaAccept = inWindow(regWrData, APER_BASE, APER_SIZE) &&
                    (regWrData[PAGE_SHIFT-1:0] == '0);
  assign eaWord   = idxOkQ ? (APER_BASE + (32'(idxQ) << PAGE_SHIFT)) : 32'h0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      idxQ    <= '0;
      idxOkQ  <= inWindow(32'h0, APER_BASE, APER_SIZE);
    end else begin
      if (wrCfg) enableQ <= regWrData[0];
      if (wrEa) begin
        idxOkQ <= eaAccept;
        idxQ   <= eaOff[PAGE_SHIFT +: IDX_W];
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      CFG_OFS:   rdNext = {31'h0, enableQ};
      EADDR_OFS: rdNext = eaWord;
      EDATA_OFS: rdNext = idxOkQ ? entryOut : 32'h0;
      default:   rdNext = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        regRdData <= 32'h0;
    else if (regRdEn) regRdData <= rdNext;
  end

  assign strb.entryWr  = regWrEn && (regAddr == EDATA_OFS) && idxOkQ;
  assign strb.xlEnable = enableQ;
  assign entryIdx      = idxQ;
  assign entryWdata    = regWrData[31:PAGE_SHIFT];

  // R2
  cfg_write_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == CFG_OFS) |=> (strb.xlEnable == $past(regWrData[0])));

  // R9
  rejected_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == EDATA_OFS && !idxOkQ) |=> (regRdData == 32'h0));
endmodule

// File: rtl/ar_dpath.sv
module ar_dpath
  import ar_pkg::*;
#(
  parameter logic [31:0] APER_BASE   = 32'h4000_0000,
  parameter int          NUM_ENTRIES = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ar_strobe_t             strb,
  input  logic [$clog2(NUM_ENTRIES)-1:0] entryIdx,
  input  logic [ENT_W-1:0]       entryWdata,
  output logic [31:0]            entryOut,
  input  logic                   xlValid,
  input  logic [31:0]            xlAddr,
  output logic                   respValid,
  output logic                   respFault,
  output logic [31:0]            respAddr
);
  localparam int          IDX_W     = $clog2(NUM_ENTRIES);
  localparam logic [32:0] APER_SIZE = 33'(NUM_ENTRIES) << PAGE_SHIFT;

  logic [ENT_W-1:0] table_q [NUM_ENTRIES];
  logic [31:0]      xlOff;
  logic [IDX_W-1:0] xlIdx;
  logic [ENT_W-1:0] xlEnt;
  logic             xlHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) table_q[i] <= '0;
    end else if (strb.entryWr) begin
      table_q[entryIdx] <= entryWdata;
    end
  end

  assign entryOut = {table_q[entryIdx], {PAGE_SHIFT{1'b0}}};

  assign xlOff = xlAddr - APER_BASE;
  assign xlIdx = xlOff[PAGE_SHIFT +: IDX_W];
  assign xlEnt = table_q[xlIdx];
  assign xlHit = strb.xlEnable && inWindow(xlAddr, APER_BASE, APER_SIZE) && xlEnt[ENT_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respFault <= 1'b0;
      respAddr  <= 32'h0;
    end else begin
      respValid <= xlValid;
      respFault <= xlValid && !xlHit;
      respAddr  <= (xlValid && xlHit) ?
                   {1'b0, xlEnt[ENT_W-2:0], xlAddr[PAGE_SHIFT-1:0]} : 32'h0;
    end
  end

  // R6
  disabled_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlValid && !strb.xlEnable) |=> (respValid && respFault));

  // R8
  outside_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlValid && ((xlAddr < APER_BASE) || ({1'b0, xlAddr} >= {1'b0, APER_BASE} + APER_SIZE)))
    |=> respFault);

  // R5
  resp_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (!respAddr[31] && !(respFault && respAddr != 32'h0)));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import ar_pkg::*;
#(
  parameter logic [31:0] APER_BASE   = 32'h4000_0000,
  parameter int          NUM_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        xlValid,
  output logic        xlReady,
  input  logic [31:0] xlAddr,
  output logic        respValid,
  output logic        respFault,
  output logic [31:0] respAddr
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  ar_strobe_t       strb;
  logic [IDX_W-1:0] entryIdx;
  logic [ENT_W-1:0] entryWdata;
  logic [31:0]      entryOut;

  assign xlReady = 1'b1;

  ar_ctrl #(.APER_BASE(APER_BASE), .NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .entryOut(entryOut), .strb(strb), .entryIdx(entryIdx), .entryWdata(entryWdata)
  );

  ar_dpath #(.APER_BASE(APER_BASE), .NUM_ENTRIES(NUM_ENTRIES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .entryIdx(entryIdx),
    .entryWdata(entryWdata), .entryOut(entryOut), .xlValid(xlValid),
    .xlAddr(xlAddr), .respValid(respValid), .respFault(respFault),
    .respAddr(respAddr)
  );
endmodule

// File: tb/aperture_remap_tb.sv
module aperture_remap_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_XL = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  ofs;
    logic [31:0] val;
    logic [31:0] exp;
    logic        flt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'h0, 32'h1,         32'h0,         1'b0, 8'd2},  // R2 enable
    '{OP_RD, 4'h0, 32'h0,         32'h1,         1'b0, 8'd2},  // R2
    '{OP_WR, 4'h4, 32'h4000_3000, 32'h0,         1'b0, 8'd3},
    '{OP_WR, 4'h8, 32'h8012_3ABC, 32'h0,         1'b0, 8'd3},
    '{OP_RD, 4'h8, 32'h0,         32'h8012_3000, 1'b0, 8'd3},  // R3 low bits dropped
    '{OP_RD, 4'h4, 32'h0,         32'h4000_3000, 1'b0, 8'd9},  // R9 readback
    '{OP_XL, 4'h0, 32'h4000_3456, 32'h0012_3456, 1'b0, 8'd5},  // R5
    '{OP_WR, 4'h4, 32'h4001_F000, 32'h0,         1'b0, 8'd3},
    '{OP_WR, 4'h8, 32'hFFFF_F000, 32'h0,         1'b0, 8'd3},
    '{OP_XL, 4'h0, 32'h4001_FFFF, 32'h7FFF_FFFF, 1'b0, 8'd5},  // R5 last page
    '{OP_XL, 4'h0, 32'h4000_5000, 32'h0,         1'b1, 8'd7},  // R7
    '{OP_XL, 4'h0, 32'h4002_0000, 32'h0,         1'b1, 8'd8},  // R8 top edge
    '{OP_XL, 4'h0, 32'h3FFF_FFFF, 32'h0,         1'b1, 8'd8},  // R8 below
    '{OP_WR, 4'h4, 32'h4000_3004, 32'h0,         1'b0, 8'd9},
    '{OP_WR, 4'h8, 32'h8000_1000, 32'h0,         1'b0, 8'd9},
    '{OP_RD, 4'h8, 32'h0,         32'h0,         1'b0, 8'd9},  // R9
    '{OP_RD, 4'h4, 32'h0,         32'h0,         1'b0, 8'd9},  // R9
    '{OP_WR, 4'h4, 32'h5000_0000, 32'h0,         1'b0, 8'd9},
    '{OP_RD, 4'h8, 32'h0,         32'h0,         1'b0, 8'd9},  // R9
    '{OP_WR, 4'h4, 32'h4000_3000, 32'h0,         1'b0, 8'd9},
    '{OP_RD, 4'h8, 32'h0,         32'h8012_3000, 1'b0, 8'd9},  // R9 unchanged
    '{OP_WR, 4'h8, 32'h0,         32'h0,         1'b0, 8'd7},
    '{OP_XL, 4'h0, 32'h4000_3456, 32'h0,         1'b1, 8'd7},  // R7 unmapped
    '{OP_WR, 4'h8, 32'h8012_3000, 32'h0,         1'b0, 8'd3},
    '{OP_RD, 4'hC, 32'h0,         32'h0,         1'b0, 8'd11}, // R11
    '{OP_WR, 4'hC, 32'hFFFF_FFFF, 32'h0,         1'b0, 8'd11},
    '{OP_RD, 4'h0, 32'h0,         32'h1,         1'b0, 8'd11}, // R11
    '{OP_XL, 4'h0, 32'h4000_3456, 32'h0012_3456, 1'b0, 8'd11}, // R11
    '{OP_WR, 4'h0, 32'h0,         32'h0,         1'b0, 8'd6},
    '{OP_XL, 4'h0, 32'h4000_3456, 32'h0,         1'b1, 8'd6},  // R6
    '{OP_RD, 4'h0, 32'h0,         32'h0,         1'b0, 8'd2},  // R2
    '{OP_WR, 4'h0, 32'h1,         32'h0,         1'b0, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        xlValid = 1'b0;
  logic        xlReady;
  logic [31:0] xlAddr = '0;
  logic        respValid, respFault;
  logic [31:0] respAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aperture_remap u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .xlValid(xlValid), .xlReady(xlReady), .xlAddr(xlAddr),
    .respValid(respValid), .respFault(respFault), .respAddr(respAddr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] ofs, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = ofs; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] ofs, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = ofs;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic xlate(input logic [31:0] a, output logic [33:0] r);
    @(negedge clk);
    xlValid = 1'b1; xlAddr = a;
    @(negedge clk);
    xlValid = 1'b0;
    r = {respValid, respFault, respAddr};
  endtask

  initial begin
    logic [31:0] d;
    logic [33:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 respValid after reset", {31'h0, respValid}, 32'h0);
    regRead(4'h0, d); check("R1 enable after reset", d, 32'h0);
    regRead(4'h4, d); check("R1 entry address after reset", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WR: regWrite(VECS[i].ofs, VECS[i].val);
        OP_RD: begin regRead(VECS[i].ofs, d); check(tag, d, VECS[i].exp); end
        default: begin
          xlate(VECS[i].val, r);
          check(tag, {r[33:32], r[31:0] == VECS[i].exp, 29'h0},
                {1'b1, VECS[i].flt, 1'b1, 29'h0});
        end
      endcase
    end

    // R10: write and translate the same page in one cycle
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h8; regWrData = 32'h8045_6000;
    xlValid = 1'b1; xlAddr = 32'h4000_3010;
    @(negedge clk);
    regWrEn = 1'b0; xlValid = 1'b0;
    check("R10 old entry used", respAddr, 32'h0012_3010);
    xlate(32'h4000_3010, r);
    check("R10 new entry after", r[31:0], 32'h0045_6010);
    regRead(4'h8, d); check("R4 read of new entry", d, 32'h8045_6000);

    // R1: reset mid-run clears table and registers
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    regRead(4'h0, d); check("R1 enable cleared", d, 32'h0);
    regRead(4'h4, d); check("R1 entry address cleared", d, 32'h0);
    regWrite(4'h0, 32'h1);
    xlate(32'h4000_3010, r); check("R1 entry 3 cleared faults", {30'h0, r[33:32]}, 32'h3);
    xlate(32'h4001_F000, r); check("R1 entry 31 cleared faults", {30'h0, r[33:32]}, 32'h3);
    regWrite(4'h4, 32'h4000_3000);
    regRead(4'h8, d); check("R1 entry 3 reads zero", d, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule